// File: doc/BRIEF.md
# Shortest-Queue Multi-Unit Instruction Dispatcher

This block sits between a pool of independent hardware threads and a set of execution units. Each thread offers its next instruction. The dispatcher takes at most one instruction per cycle and reads the operation class from the instruction. It works out which units can run that class, and writes the instruction into the least occupied of those units' private queues. The units drain their own queues at their own pace and report completion with the thread number.

A thread stays blocked from the moment one of its instructions is queued until a unit reports that instruction finished. No dependency tracking is therefore needed. Threads are independent of each other, so their instructions may finish in any relative order. An instruction whose class no unit supports is consumed and flagged. A supported instruction with every capable queue full waits at its thread's input.

Top module: `sq_dispatch`

## Requirements
- R1: The operation class is the low CW bits of the instruction word (CW = clog2 of the class count, 2 by default). An instruction is written only into the queue of a unit whose capability mask has a 1 at that class. Unit u's mask is bits [u*NC +: NC] of UNIT_CAPS; the default gives unit0 classes {0,1}, unit1 {1,2} and unit2 {1}.
- R2: Among capable units whose queue is not full, the instruction goes to the queue holding the fewest entries. Occupancy is taken before this cycle's pops.
- R3: When several eligible queues hold the same lowest count, the lowest-numbered unit receives the instruction.
- R4: A full queue is not eligible. If every capable queue is full, the offering thread sees thr_ready low, nothing is queued, err_drop stays low, and the offer is taken in the first cycle a capable queue has room.
- R5: At most one thread is accepted per cycle. The candidates are threads with thr_valid high that are not blocked. The pick starts from a round-robin pointer and moves upward with wrap-around. After any acceptance the pointer moves to the accepted thread plus one, wrapping to 0 after the last thread.
- R6: A thread whose instruction was queued is blocked until a done_valid pulse carries its thread number. Its thr_ready stays low while it is blocked. It can be accepted again in the cycle after that completion.
- R7: An instruction whose class no unit supports is accepted (thr_ready high) with err_drop high in the same cycle. It is not queued, and its thread is not blocked.
- R8: Each queue is first-in first-out. unit_valid, unit_instr and unit_tid show the oldest entry. unit_pop with unit_valid high removes that entry at the next edge. A push and a pop on the same queue in one cycle leave its count unchanged.
- R9: After reset all queues are empty (unit_valid all 0), no thread is blocked, and the round-robin pointer is at thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_valid | input | NT | Thread t offers an instruction |
| thr_instr | input | NT*IW | Instruction words, thread t at [t*IW +: IW] |
| thr_ready | output | NT | One-hot acceptance of the offering thread |
| err_drop | output | 1 | Accepted instruction had an unsupported class and was dropped |
| unit_valid | output | NU | Queue u holds at least one entry |
| unit_instr | output | NU*IW | Oldest instruction of queue u |
| unit_tid | output | NU*TW | Thread number of the oldest entry of queue u |
| unit_pop | input | NU | Unit u takes its oldest entry |
| done_valid | input | NU | Unit u reports a finished instruction |
| done_tid | input | NU*TW | Thread number of the finished instruction |

## Verification
thr_ready and err_drop are combinational in the current offers and the current queue state, so they are due in the same cycle. The bench drives inputs on the falling edge and compares these two outputs 1 ns later against a model computed from the requirements. Queue heads, occupancy and the blocked flags change only at the rising edge, so their results are due one edge after the stimulus. The bench compares unit_valid, unit_instr and unit_tid against the model's queues before each new stimulus, and probes them 1 ns after the edge in the directed cases. A completion therefore frees its thread one cycle later, and the checks are placed in that cycle.

// File: rtl/sq_dispatch_pkg.sv
package sq_dispatch_pkg;

  // result of a priority search: found flag and index (up to 32 entries)
  typedef struct packed {
    logic       hit;
    logic [4:0] idx;
  } pick_t;

  // first set bit of req, searching upward from start with wrap at n
  function automatic pick_t rr_first(input logic [31:0] req,
                                     input int unsigned start,
                                     input int unsigned n);
    pick_t       p;
    int unsigned pos;
    p = '0;
    for (int unsigned k = 0; k < 32; k++) begin
      if (k < n) begin
        pos = start + k;
        if (pos >= n) pos = pos - n;
        if (!p.hit && req[pos[4:0]]) begin
          p.hit = 1'b1;
          p.idx = pos[4:0];
        end
      end
    end
    return p;
  endfunction

  // increment with wrap to zero at n
  function automatic int unsigned wrap_inc(input int unsigned v,
                                           input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/sq_rr_pick.sv
module sq_rr_pick
  import sq_dispatch_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          hit,
  output logic [IW-1:0] idx
);

  pick_t pick;

  always_comb begin
    pick = rr_first(32'(req), int'(start), N);
    hit  = pick.hit;
    idx  = IW'(pick.idx);
  end

endmodule

// File: rtl/sq_unit_select.sv
module sq_unit_select #(
  parameter int NU   = 3,
  parameter int NC   = 4,
  parameter int CW   = 2,
  parameter int CNTW = 3,
  parameter int UW   = 2,
  parameter int QD   = 4,
  parameter logic [NU*NC-1:0] CAPS = '1
) (
  input  logic [CW-1:0]      cls,
  input  logic [NU*CNTW-1:0] counts,
  input  logic [NU-1:0]      full,
  output logic [NU-1:0]      capable,
  output logic               cap_any,
  output logic               hit,
  output logic [UW-1:0]      idx
);

  // which units can execute the given class
  function automatic logic [NU-1:0] cap_mask(input logic [CW-1:0] c);
    logic [NU-1:0] m;
    m = '0;
    for (int u = 0; u < NU; u++) begin
      if (int'(c) < NC) m[u] = CAPS[u*NC + int'(c)];
    end
    return m;
  endfunction

  // lowest count among eligible units; strict compare keeps the lowest index on ties
  function automatic logic [UW:0] pick_shortest(input logic [NU-1:0] elig,
                                                input logic [NU*CNTW-1:0] cnt);
    logic            found;
    logic [UW-1:0]   best;
    logic [CNTW-1:0] best_cnt;
    found    = 1'b0;
    best     = '0;
    best_cnt = CNTW'(QD);
    for (int u = 0; u < NU; u++) begin
      if (elig[u] && (!found || cnt[u*CNTW +: CNTW] < best_cnt)) begin
        found    = 1'b1;
        best     = UW'(u);
        best_cnt = cnt[u*CNTW +: CNTW];
      end
    end
    return {found, best};
  endfunction

  logic [NU-1:0] elig;
  logic [UW:0]   res;

  always_comb begin
    capable = cap_mask(cls);
    cap_any = |capable;
    elig    = capable & ~full;
    res     = pick_shortest(elig, counts);
    hit     = res[UW];
    idx     = res[UW-1:0];
  end

endmodule

// File: rtl/sq_queue.sv
module sq_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    din,
  input  logic            pop,
  output logic [W-1:0]    dout,
  output logic            nonempty,
  output logic            full,
  output logic [CNTW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign nonempty = (count != '0);
  assign full     = (count == CNTW'(DEPTH));
  assign do_push  = push & ~full;
  assign do_pop   = pop & nonempty;
  assign dout     = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      count <= '0;
    end else begin
      if (do_push) wr_q <= ptr_next(wr_q);
      if (do_pop)  rd_q <= ptr_next(rd_q);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/sq_dispatch.sv
module sq_dispatch
  import sq_dispatch_pkg::*;
#(
  parameter int NT = 8,
  parameter int NU = 3,
  parameter int NC = 4,
  parameter int IW = 12,
  parameter int QD = 4,
  parameter logic [NU*NC-1:0] UNIT_CAPS = 12'h263,
  localparam int TW   = (NT > 1) ? $clog2(NT) : 1,
  localparam int UW   = (NU > 1) ? $clog2(NU) : 1,
  localparam int CW   = (NC > 1) ? $clog2(NC) : 1,
  localparam int CNTW = $clog2(QD + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NT-1:0]   thr_valid,
  input  logic [NT*IW-1:0] thr_instr,
  output logic [NT-1:0]   thr_ready,
  output logic            err_drop,
  output logic [NU-1:0]   unit_valid,
  output logic [NU*IW-1:0] unit_instr,
  output logic [NU*TW-1:0] unit_tid,
  input  logic [NU-1:0]   unit_pop,
  input  logic [NU-1:0]   done_valid,
  input  logic [NU*TW-1:0] done_tid
);

  // named internal events (observed by the bound checker)
  logic [NT-1:0]      busy_q;
  logic [TW-1:0]      rr_ptr_q;
  logic [NT-1:0]      avail;
  logic               t_hit;
  logic [TW-1:0]      t_idx;
  logic [IW-1:0]      sel_instr;
  logic [CW-1:0]      disp_cls;
  logic [NU-1:0]      capable;
  logic               cap_any;
  logic               u_hit;
  logic [UW-1:0]      u_idx;
  logic               accept, dispatch, drop;
  logic [NU-1:0]      q_push, q_pop, q_full, q_nonempty;
  logic [NU*CNTW-1:0] q_count;
  logic [NT-1:0]      done_clr, busy_set;

  function automatic logic [NT-1:0] tid_onehot(input logic [TW-1:0] t);
    logic [NT-1:0] m;
    m = '0;
    for (int i = 0; i < NT; i++) if (TW'(i) == t) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [NT-1:0] done_mask(input logic [NU-1:0] dv,
                                              input logic [NU*TW-1:0] dt);
    logic [NT-1:0] m;
    m = '0;
    for (int u = 0; u < NU; u++) if (dv[u]) m = m | tid_onehot(dt[u*TW +: TW]);
    return m;
  endfunction

  assign avail = thr_valid & ~busy_q;

  sq_rr_pick #(.N(NT), .IW(TW)) u_rr (
    .req   (avail),
    .start (rr_ptr_q),
    .hit   (t_hit),
    .idx   (t_idx)
  );

  always_comb begin
    sel_instr = '0;
    for (int t = 0; t < NT; t++) begin
      if (TW'(t) == t_idx) sel_instr = thr_instr[t*IW +: IW];
    end
  end

  assign disp_cls = sel_instr[CW-1:0];

  sq_unit_select #(
    .NU(NU), .NC(NC), .CW(CW), .CNTW(CNTW), .UW(UW), .QD(QD), .CAPS(UNIT_CAPS)
  ) u_sel (
    .cls     (disp_cls),
    .counts  (q_count),
    .full    (q_full),
    .capable (capable),
    .cap_any (cap_any),
    .hit     (u_hit),
    .idx     (u_idx)
  );

  assign dispatch  = t_hit & cap_any & u_hit;
  assign drop      = t_hit & ~cap_any;
  assign accept    = dispatch | drop;
  assign q_push    = dispatch ? (NU'(1) << u_idx) : '0;
  assign thr_ready = accept ? tid_onehot(t_idx) : '0;
  assign err_drop  = drop;
  assign q_pop     = unit_pop & q_nonempty;
  assign done_clr  = done_mask(done_valid, done_tid);
  assign busy_set  = dispatch ? tid_onehot(t_idx) : '0;

  genvar gu;
  generate
    for (gu = 0; gu < NU; gu++) begin : g_unit
      logic [IW+TW-1:0] head;
      sq_queue #(.DEPTH(QD), .W(IW + TW)) u_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (q_push[gu]),
        .din      ({t_idx, sel_instr}),
        .pop      (q_pop[gu]),
        .dout     (head),
        .nonempty (q_nonempty[gu]),
        .full     (q_full[gu]),
        .count    (q_count[gu*CNTW +: CNTW])
      );
      assign unit_instr[gu*IW +: IW] = head[IW-1:0];
      assign unit_tid[gu*TW +: TW]   = head[IW +: TW];
    end
  endgenerate

  assign unit_valid = q_nonempty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= '0;
      rr_ptr_q <= '0;
    end else begin
      busy_q <= (busy_q & ~done_clr) | busy_set;
      if (accept) rr_ptr_q <= TW'(wrap_inc(int'(t_idx), NT));
    end
  end

endmodule

// File: rtl/sq_dispatch_chk.sv
module sq_dispatch_chk #(
  parameter int NT = 8,
  parameter int NU = 3,
  parameter int NC = 4,
  parameter int CW = 2,
  parameter int CNTW = 3,
  parameter logic [NU*NC-1:0] CAPS = '1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NT-1:0]      thr_ready,
  input logic               err_drop,
  input logic [NT-1:0]      busy,
  input logic [NU-1:0]      q_push,
  input logic [NU-1:0]      q_pop,
  input logic [NU-1:0]      q_full,
  input logic [NU*CNTW-1:0] q_count,
  input logic [CW-1:0]      disp_cls
);

  p_one_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(thr_ready) && $onehot0(q_push));

  p_drop_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_drop |-> (q_push == '0) && ($countones(thr_ready) == 1));

  genvar gt, gu, gv;
  generate
    for (gt = 0; gt < NT; gt++) begin : g_thr
      p_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy[gt] |-> !thr_ready[gt]);
    end
    for (gu = 0; gu < NU; gu++) begin : g_u
      p_capable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q_push[gu] |-> CAPS[gu*NC + int'(disp_cls)]);
      p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q_push[gu] |-> !q_full[gu]);
      p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_push[gu] && q_pop[gu]) |=>
          (q_count[gu*CNTW +: CNTW] == $past(q_count[gu*CNTW +: CNTW])));
      for (gv = 0; gv < NU; gv++) begin : g_v
        if (gv != gu) begin : g_ne
          p_shortest_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (q_push[gu] && CAPS[gv*NC + int'(disp_cls)] && !q_full[gv]) |->
              (q_count[gu*CNTW +: CNTW] <= q_count[gv*CNTW +: CNTW]));
        end
        if (gv < gu) begin : g_lt
          p_tie_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (q_push[gu] && CAPS[gv*NC + int'(disp_cls)] && !q_full[gv]) |->
              (q_count[gu*CNTW +: CNTW] < q_count[gv*CNTW +: CNTW]));
        end
      end
    end
  endgenerate

endmodule

bind sq_dispatch sq_dispatch_chk #(
  .NT(NT), .NU(NU), .NC(NC), .CW(CW), .CNTW(CNTW), .CAPS(UNIT_CAPS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .thr_ready (thr_ready),
  .err_drop  (err_drop),
  .busy      (busy_q),
  .q_push    (q_push),
  .q_pop     (q_pop),
  .q_full    (q_full),
  .q_count   (q_count),
  .disp_cls  (disp_cls)
);

// File: tb/sq_dispatch_test.sv
module sq_dispatch_test;

  localparam int NT = 8, NU = 3, NC = 4, IW = 12, QD = 4, TW = 3;
  localparam logic [NU*NC-1:0] CAPS = 12'h263;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NT-1:0]    thr_valid = '0, thr_ready;
  logic [NT*IW-1:0] thr_instr = '0;
  logic             err_drop;
  logic [NU-1:0]    unit_valid, unit_pop = '0, done_valid = '0;
  logic [NU*IW-1:0] unit_instr;
  logic [NU*TW-1:0] unit_tid, done_tid = '0;

  always #2 clk = ~clk;   // 250 MHz

  sq_dispatch uut (.*);

  int checks = 0, errors = 0;

  // stimulus
  logic [NT-1:0] drv_valid;
  logic [IW-1:0] drv_instr [NT];
  logic [NU-1:0] drv_pop;

  // reference model
  int            mptr;
  bit            mbusy [NT];
  int            mcnt  [NU];
  int            mq_tid [NU][QD];
  logic [IW-1:0] mq_ins [NU][QD];
  logic [NT-1:0] obs_ready;
  logic          obs_err;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit can_run(input int u, input int c);
    return CAPS[u*NC + c];
  endfunction

  task automatic step();
    int            e_thr, e_unit, c;
    bit            any_cap;
    logic [NT-1:0] e_ready;
    bit            e_err;
    @(negedge clk);
    thr_valid = drv_valid;
    for (int t = 0; t < NT; t++) thr_instr[t*IW +: IW] = drv_instr[t];
    unit_pop   = drv_pop;
    done_valid = drv_pop;
    for (int u = 0; u < NU; u++) done_tid[u*TW +: TW] = TW'(mq_tid[u][0]);
    e_thr = -1; e_unit = -1; e_ready = '0; e_err = 1'b0;
    for (int k = 0; k < NT; k++) begin
      int t = (mptr + k) % NT;
      if (e_thr < 0 && drv_valid[t] && !mbusy[t]) e_thr = t;
    end
    if (e_thr >= 0) begin
      c = int'(drv_instr[e_thr][1:0]);
      any_cap = 1'b0;
      for (int u = 0; u < NU; u++) begin
        if (can_run(u, c)) begin
          any_cap = 1'b1;
          if (mcnt[u] < QD && (e_unit < 0 || mcnt[u] < mcnt[e_unit])) e_unit = u;
        end
      end
      if (!any_cap) begin e_err = 1'b1; e_ready[e_thr] = 1'b1; end
      else if (e_unit >= 0) e_ready[e_thr] = 1'b1;
    end
    #1;
    obs_ready = thr_ready;
    obs_err   = err_drop;
    chk("R5 R6 R4 thr_ready", 32'(thr_ready), 32'(e_ready));
    chk("R7 err_drop", 32'(err_drop), 32'(e_err));
    for (int u = 0; u < NU; u++) begin
      chk("R8 unit_valid", 32'(unit_valid[u]), 32'(mcnt[u] > 0));
      if (mcnt[u] > 0) begin
        chk("R8 R2 unit_tid", 32'(unit_tid[u*TW +: TW]), 32'(mq_tid[u][0]));
        chk("R8 R1 unit_instr", 32'(unit_instr[u*IW +: IW]), 32'(mq_ins[u][0]));
      end
    end
    @(posedge clk);
    for (int u = 0; u < NU; u++) begin
      if (drv_pop[u]) begin
        mbusy[mq_tid[u][0]] = 1'b0;
        for (int i = 0; i < QD - 1; i++) begin
          mq_tid[u][i] = mq_tid[u][i+1];
          mq_ins[u][i] = mq_ins[u][i+1];
        end
        mcnt[u]--;
      end
    end
    if (e_unit >= 0 && e_thr >= 0) begin
      mq_tid[e_unit][mcnt[e_unit]] = e_thr;
      mq_ins[e_unit][mcnt[e_unit]] = drv_instr[e_thr];
      mcnt[e_unit]++;
      mbusy[e_thr] = 1'b1;
    end
    if (e_ready != '0) mptr = (e_thr + 1) % NT;
  endtask

  task automatic offer1(input int t, input logic [IW-1:0] ins, input logic [NU-1:0] pop);
    drv_valid = '0;
    drv_valid[t] = 1'b1;
    drv_instr[t] = ins;
    drv_pop = pop;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    mptr = 0;
    for (int t = 0; t < NT; t++) begin mbusy[t] = 1'b0; drv_instr[t] = '0; end
    for (int u = 0; u < NU; u++) mcnt[u] = 0;
    drv_valid = '0; drv_pop = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R9 reset unit_valid", 32'(unit_valid), 32'h0);
    chk("R9 reset thr_ready", 32'(thr_ready), 32'h0);
    chk("R9 reset err_drop", 32'(err_drop), 32'h0);

    offer1(0, 12'h0A1, '0); #1;                 // class 1, all queues empty
    chk("R3 tie goes to unit0", 32'(unit_valid), 32'h1);
    offer1(1, 12'h0B5, '0); #1;                 // class 1, counts 1,0,0
    chk("R2 R3 shortest then lowest", 32'(unit_valid), 32'h3);
    offer1(2, 12'h0C0, '0);                     // class 0 -> unit0 only
    offer1(3, 12'h0D2, '0);                     // class 2 -> unit1 only
    offer1(4, 12'h0E1, '0); #1;                 // class 1, counts 2,2,0
    chk("R2 shortest unit2", 32'(unit_valid), 32'h7);
    chk("R2 unit2 thread", 32'(unit_tid[2*TW +: TW]), 32'd4);
    offer1(5, 12'h0F3, '0);                     // class 3 unsupported
    chk("R7 drop accepted", 32'(obs_ready), 32'h20);
    chk("R7 drop flagged", 32'(obs_err), 32'h1);
    offer1(5, 12'h0F7, '0);                     // thread still free after drop
    chk("R7 thread not blocked", 32'(obs_ready), 32'h20);
    offer1(0, 12'h0A1, '0);                     // thread0 still blocked
    chk("R6 blocked thread", 32'(obs_ready), 32'h0);
    offer1(5, 12'h100, '0);                     // unit0 -> 3 entries
    offer1(6, 12'h104, '0);                     // unit0 -> 4 entries (full)
    offer1(7, 12'h108, '0);
    chk("R4 stall on full", 32'(obs_ready), 32'h0);
    chk("R4 stall no error", 32'(obs_err), 32'h0);
    offer1(7, 12'h108, 3'b001); #1;            // pop thread0's entry, still full this cycle
    chk("R4 full judged before pop", 32'(obs_ready), 32'h0);
    chk("R8 fifo order head", 32'(unit_tid[0 +: TW]), 32'd2);
    offer1(7, 12'h108, '0);
    chk("R4 accepted after room", 32'(obs_ready), 32'h80);
    offer1(0, 12'h0A1, '0);                     // freed by completion
    chk("R6 accepted after done", 32'(obs_ready), 32'h1);

    for (int n = 0; n < 3000; n++) begin       // R5 R8 random traffic
      for (int t = 0; t < NT; t++) begin
        drv_valid[t] = ($urandom % 3) != 0;
        drv_instr[t] = IW'($urandom);
        drv_instr[t][1:0] = (($urandom % 8) == 0) ? 2'd3 : 2'($urandom % 3);
      end
      for (int u = 0; u < NU; u++) drv_pop[u] = (mcnt[u] > 0) && (($urandom % 3) == 0);
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule